// File: doc/BRIEF.md
# Windowed Activity Energy and Power Monitor

This block estimates the energy and average power of one microarchitectural component, such as a cache, a queue or a register file, from the activity of that component. Each clock cycle it can receive a read strobe and a write strobe. It counts these strobes over a programmable window of enabled cycles and weights each count by its own per-access energy. It also adds a per-cycle leakage energy for every enabled cycle, so an idle component still accrues static energy. When a built-in parameter marks the component as a logic unit, such as a decoder or an ALU, only one access type is counted. In that case the read strobe acts as the logic-access strobe.

Energies are unsigned picojoule values. The clock frequency is given in MHz, so the average power comes out in microwatts. When a window closes, the block takes a snapshot of the dynamic and static energy and starts a sequential divider. The divider computes (dynamic + static) times the frequency, divided by the window length. When it finishes, the energy and power outputs update together with a one-cycle valid pulse.

Configuration goes through a small write port that is accepted only while the monitor is disabled. A synchronous clear restarts the counters, the accumulators, the window position and any division in flight.

Top module: `act_energy_mon`

## Requirements
- R1: After reset, busy, res_valid, dyn_energy, stat_energy and avg_power are all zero. The window length resets to 1, the frequency to 1 and the three energy coefficients to 0.
- R2: The dynamic energy of a window is the read count times the per-read energy plus the write count times the per-write energy. Configuration addresses on cfg_addr are: 0 per-read energy, 1 per-write energy, 2 static energy per cycle, 3 window length, 4 frequency in MHz.
- R3: The static energy of a window is the per-cycle static coefficient times the number of enabled cycles in it. It accrues even in a window with no accesses, which then reports zero dynamic energy.
- R4: avg_power equals floor((dynamic + static) × frequency / window length), in microwatts. For example, 20 reads at 500 pJ plus 12 writes at 600 pJ over 50 cycles at 2000 MHz gives 17200 pJ and 688000 µW.
- R5: A window closes on its n-th enabled cycle. A strobe on that closing cycle counts in the closing window, and a strobe on the next enabled cycle counts in the next window. Cycles with en low add neither events nor static energy, and they do not advance the window.
- R6: res_valid is high for exactly one cycle per result. The three result outputs change only in that cycle and hold their values otherwise.
- R7: busy is high while a division is in flight. A window that closes while busy is high produces no result, and its counts are discarded.
- R8: The event counters (CNT_W bits) and the static accumulator saturate at their maximum instead of wrapping.
- R9: A configuration write made while en is high is ignored.
- R10: clr clears the counters, the static accumulator and the window position, and aborts a division in progress. Events before clr do not reach any later result.
- R11: With LOGIC_UNIT set, wr_evt is ignored and the dynamic energy is the count of rd_evt strobes times the per-read energy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of counters, accumulators, window and divider |
| en | input | 1 | Monitor enable; the window advances on enabled cycles |
| rd_evt | input | 1 | Read strobe (logic-access strobe when LOGIC_UNIT is set) |
| wr_evt | input | 1 | Write strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select (see R2) |
| cfg_wdata | input | COEF_W (16) | Configuration write data |
| busy | output | 1 | Division in flight |
| res_valid | output | 1 | One-cycle result pulse |
| dyn_energy | output | ENERGY_W (40) | Dynamic energy of the last reported window, pJ |
| stat_energy | output | ENERGY_W (40) | Static energy of the last reported window, pJ |
| avg_power | output | ENERGY_W+COEF_W (56) | Average power of the last reported window, µW |

## Verification
A wrong count or a wrong accumulator state does not show at the ports while the window runs. It appears only at the next res_valid pulse, in dyn_energy or stat_energy. That pulse comes roughly one divider latency (about 58 cycles) after the window closes. A misplaced window boundary shifts one event between two consecutive results, so the bench checks adjacent windows that have strobes on both sides of the boundary. A wrong divider state corrupts only avg_power. An error in the busy lock shows up as an extra result pulse or a missing one, so the bench counts pulses as well as checking values.

// File: rtl/aem_pkg.sv
package aem_pkg;
    typedef enum logic [2:0] {
        CFG_E_RD   = 3'd0,
        CFG_E_WR   = 3'd1,
        CFG_E_STAT = 3'd2,
        CFG_WIN    = 3'd3,
        CFG_FREQ   = 3'd4
    } cfg_addr_e;
endpackage

// File: rtl/aem_sat_acc.sv
module aem_sat_acc #(
    parameter int W     = 12,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [INC_W-1:0] inc,
    input  logic             take,
    output logic [W-1:0]     sum_next
);
    logic [W-1:0] acc_d, acc_q;
    logic [W:0]   wide;

    always_comb begin
        wide     = {1'b0, acc_q} + (W+1)'(inc);
        sum_next = add_en ? (wide[W] ? {W{1'b1}} : wide[W-1:0]) : acc_q;
        if (clr || take) acc_d = '0;
        else             acc_d = sum_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R8: between clears the accumulated value never drops (no wrap)
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !take) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/aem_seq_div.sv
module aem_seq_div #(
    parameter int DW = 56,
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [NW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quotient
);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [NW-1:0] dvs;
        logic [NW-1:0] rem;
        logic [DW-1:0] quo;
    } div_t;

    div_t    s_d, s_q;
    logic [NW:0] trial;
    logic [NW:0] diff;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        trial    = {s_q.rem, s_q.quo[DW-1]};
        diff     = trial - {1'b0, s_q.dvs};
        if (abort) begin
            s_d.busy = 1'b0;
        end else if (start && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.dvs  = divisor;
            s_d.rem  = '0;
            s_d.quo  = dividend;
        end else if (s_q.busy) begin
            if (trial >= {1'b0, s_q.dvs}) begin
                s_d.rem = diff[NW-1:0];
                s_d.quo = {s_q.quo[DW-2:0], 1'b1};
            end else begin
                s_d.rem = trial[NW-1:0];
                s_d.quo = {s_q.quo[DW-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CW'(DW-1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign quotient = s_q.quo;

    // R7: a finished division is never still running
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !s_q.busy);
    // R7: the caller never restarts a division in flight
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |-> !s_q.busy);
endmodule

// File: rtl/act_energy_mon.sv
module act_energy_mon
    import aem_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int COEF_W     = 16,
    parameter int ENERGY_W   = 40,
    parameter bit LOGIC_UNIT = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en,
    input  logic                       rd_evt,
    input  logic                       wr_evt,
    input  logic                       cfg_we,
    input  logic [2:0]                 cfg_addr,
    input  logic [COEF_W-1:0]          cfg_wdata,
    output logic                       busy,
    output logic                       res_valid,
    output logic [ENERGY_W-1:0]        dyn_energy,
    output logic [ENERGY_W-1:0]        stat_energy,
    output logic [ENERGY_W+COEF_W-1:0] avg_power
);
    localparam int PROD_W = ENERGY_W + COEF_W;
    localparam int DYN_W  = CNT_W + COEF_W + 1;

    typedef struct packed {
        logic [COEF_W-1:0]   c_rd;
        logic [COEF_W-1:0]   c_wr;
        logic [COEF_W-1:0]   c_st;
        logic [COEF_W-1:0]   c_win;
        logic [COEF_W-1:0]   c_frq;
        logic [COEF_W-1:0]   win;
        logic [ENERGY_W-1:0] p_dyn;
        logic [ENERGY_W-1:0] p_stat;
        logic [ENERGY_W-1:0] o_dyn;
        logic [ENERGY_W-1:0] o_stat;
        logic [PROD_W-1:0]   o_pow;
        logic                o_vld;
    } mon_t;

    mon_t s_d, s_q;

    logic [CNT_W-1:0]    rd_tot, wr_tot;
    logic [ENERGY_W-1:0] st_tot;
    logic [COEF_W-1:0]   n_eff;
    logic                close, start;
    logic                div_busy, div_done;
    logic [PROD_W-1:0]   div_q, dividend;
    logic [DYN_W-1:0]    dyn_full;
    logic [ENERGY_W:0]   tot_w;
    logic [ENERGY_W-1:0] tot;

    assign n_eff = (s_q.c_win == '0) ? COEF_W'(1) : s_q.c_win;
    assign close = en && !clr && (s_q.win >= n_eff - 1'b1);
    assign start = close && !div_busy;

    aem_sat_acc #(.W(CNT_W), .INC_W(1)) u_rd_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .add_en(en & rd_evt),
        .inc(1'b1), .take(close), .sum_next(rd_tot));

    generate
        if (LOGIC_UNIT) begin : g_logic
            assign wr_tot = '0;
        end else begin : g_store
            aem_sat_acc #(.W(CNT_W), .INC_W(1)) u_wr_cnt (
                .clk(clk), .rst_n(rst_n), .clr(clr), .add_en(en & wr_evt),
                .inc(1'b1), .take(close), .sum_next(wr_tot));
        end
    endgenerate

    aem_sat_acc #(.W(ENERGY_W), .INC_W(COEF_W)) u_st_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .add_en(en),
        .inc(s_q.c_st), .take(close), .sum_next(st_tot));

    always_comb begin
        dyn_full = DYN_W'(rd_tot) * DYN_W'(s_q.c_rd)
                 + DYN_W'(wr_tot) * DYN_W'(s_q.c_wr);
        tot_w    = (ENERGY_W+1)'(dyn_full) + {1'b0, st_tot};
        tot      = tot_w[ENERGY_W] ? {ENERGY_W{1'b1}} : tot_w[ENERGY_W-1:0];
        dividend = PROD_W'(tot) * PROD_W'(s_q.c_frq);
    end

    aem_seq_div #(.DW(PROD_W), .NW(COEF_W)) u_div (
        .clk(clk), .rst_n(rst_n), .abort(clr), .start(start),
        .dividend(dividend), .divisor(n_eff),
        .busy(div_busy), .done(div_done), .quotient(div_q));

    always_comb begin
        s_d       = s_q;
        s_d.o_vld = 1'b0;
        if (cfg_we && !en) begin
            case (cfg_addr_e'(cfg_addr))
                CFG_E_RD:   s_d.c_rd  = cfg_wdata;
                CFG_E_WR:   s_d.c_wr  = cfg_wdata;
                CFG_E_STAT: s_d.c_st  = cfg_wdata;
                CFG_WIN:    s_d.c_win = cfg_wdata;
                CFG_FREQ:   s_d.c_frq = cfg_wdata;
                default:    ;
            endcase
        end
        if (clr)     s_d.win = '0;
        else if (en) s_d.win = close ? '0 : s_q.win + 1'b1;
        if (start) begin
            s_d.p_dyn  = ENERGY_W'(dyn_full);
            s_d.p_stat = st_tot;
        end
        if (div_done && !clr) begin
            s_d.o_dyn  = s_q.p_dyn;
            s_d.o_stat = s_q.p_stat;
            s_d.o_pow  = div_q;
            s_d.o_vld  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.c_win <= COEF_W'(1);
            s_q.c_frq <= COEF_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = div_busy;
    assign res_valid   = s_q.o_vld;
    assign dyn_energy  = s_q.o_dyn;
    assign stat_energy = s_q.o_stat;
    assign avg_power   = s_q.o_pow;

    // R6: the result strobe lasts a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R6: results hold outside the strobe
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(dyn_energy) && $stable(stat_energy) && $stable(avg_power)));
    // R9: coefficients stay put while monitoring
    a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($stable(s_q.c_rd) && $stable(s_q.c_wr) && $stable(s_q.c_st)
                && $stable(s_q.c_win) && $stable(s_q.c_frq)));
    // R10: clear restarts the window and stops the divider
    a_r10_clr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.win == '0 && !busy));
endmodule

// File: tb/tb_act_energy_mon.sv
module tb_act_energy_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, en = 1'b0, rd_evt = 1'b0, wr_evt = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        busy, res_valid, busy_l, vld_l;
    logic [39:0] dyn_energy, stat_energy, dyn_l, stat_l;
    logic [55:0] avg_power, pow_l;

    always #4 clk = ~clk;

    act_energy_mon dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .rd_evt(rd_evt), .wr_evt(wr_evt),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .busy(busy), .res_valid(res_valid), .dyn_energy(dyn_energy),
        .stat_energy(stat_energy), .avg_power(avg_power));

    act_energy_mon #(.LOGIC_UNIT(1'b1)) dut_logic (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .rd_evt(rd_evt), .wr_evt(wr_evt),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .busy(busy_l), .res_valid(vld_l), .dyn_energy(dyn_l),
        .stat_energy(stat_l), .avg_power(pow_l));

    int nchk = 0, nfail = 0, nres = 0, nres_l = 0;
    longint r_dyn[8], r_st[8], r_pow[8], l_dyn[8], l_st[8], l_pow[8];

    always @(negedge clk) begin
        if (res_valid) begin
            r_dyn[nres % 8] = longint'(dyn_energy);
            r_st[nres % 8]  = longint'(stat_energy);
            r_pow[nres % 8] = longint'(avg_power);
            nres = nres + 1;
        end
        if (vld_l) begin
            l_dyn[nres_l % 8] = longint'(dyn_l);
            l_st[nres_l % 8]  = longint'(stat_l);
            l_pow[nres_l % 8] = longint'(pow_l);
            nres_l = nres_l + 1;
        end
    end

    typedef struct packed {
        int nrd; int nwr; int erd; int ewr; int es; int n; int f;
        longint e_dyn; longint e_st; longint e_pow;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{20, 12, 500, 600, 0, 50, 2000, 64'd17200, 64'd0,   64'd688000},
        '{0,  0,  500, 600, 7, 20, 100,  64'd0,     64'd140, 64'd700},
        '{10, 10, 3,   5,   2, 10, 1000, 64'd80,    64'd20,  64'd10000},
        '{5,  0,  1000, 0,  0, 8,  3,    64'd5000,  64'd0,   64'd1875}
    };

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int erd, input int ewr, input int es, input int n, input int f);
        en = 1'b0;
        cfg_wr(0, erd); cfg_wr(1, ewr); cfg_wr(2, es); cfg_wr(3, n); cfg_wr(4, f);
    endtask

    task automatic do_clr();
        clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
    endtask

    task automatic run(input int n, input int nrd, input int nwr);
        for (int c = 0; c < n; c++) begin
            en = 1'b1; rd_evt = (c < nrd); wr_evt = (c < nwr);
            @(negedge clk);
        end
        en = 1'b0; rd_evt = 1'b0; wr_evt = 1'b0;
    endtask

    task automatic wait_res(input int target, input string tag);
        int t = 0;
        while (nres < target && t < 400) begin @(posedge clk); t++; end
        @(negedge clk);
        if (nres < target) chk({tag, " result timeout"}, nres, target);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 res_valid", res_valid, 0);
        chk("R1 dyn", dyn_energy, 0);
        chk("R1 stat", stat_energy, 0);
        chk("R1 power", avg_power, 0);

        // R2 R3 R4 vector table, R11 on the first vector
        foreach (VECS[i]) begin
            base = nres;
            setup(VECS[i].erd, VECS[i].ewr, VECS[i].es, VECS[i].n, VECS[i].f);
            do_clr();
            run(VECS[i].n, VECS[i].nrd, VECS[i].nwr);
            wait_res(base + 1, "R4");
            chk("R2 dyn energy", r_dyn[base % 8], VECS[i].e_dyn);
            chk("R3 static energy", r_st[base % 8], VECS[i].e_st);
            chk("R4 avg power", r_pow[base % 8], VECS[i].e_pow);
            if (i == 0) begin
                chk("R11 logic dyn", l_dyn[(nres_l - 1) % 8], 10000);
                chk("R11 logic power", l_pow[(nres_l - 1) % 8], 400000);
            end
        end

        // R9 writes while enabled are dropped
        base = nres;
        setup(7, 0, 0, 5, 1);
        do_clr();
        for (int c = 0; c < 5; c++) begin
            en = 1'b1; rd_evt = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 16'd999;
            @(negedge clk);
        end
        en = 1'b0; rd_evt = 1'b0; cfg_we = 1'b0;
        wait_res(base + 1, "R9");
        chk("R9 cfg locked dyn", r_dyn[base % 8], 35);

        // R10 clear drops earlier events
        base = nres;
        setup(1, 0, 0, 20, 1);
        do_clr();
        run(10, 10, 0);
        do_clr();
        run(20, 3, 0);
        wait_res(base + 1, "R10");
        chk("R10 dyn after clr", r_dyn[base % 8], 3);
        chk("R10 result count", nres, base + 1);

        // R5 boundary events and disabled gap
        base = nres;
        setup(1, 0, 2, 100, 1);
        do_clr();
        for (int c = 0; c < 210; c++) begin
            en = !(c >= 60 && c < 70);
            rd_evt = (c >= 60 && c < 70) || c == 109 || c == 110;
            @(negedge clk);
        end
        en = 1'b0; rd_evt = 1'b0;
        wait_res(base + 2, "R5");
        chk("R5 window1 dyn", r_dyn[base % 8], 1);
        chk("R5 window1 stat", r_st[base % 8], 200);
        chk("R5 window2 dyn", r_dyn[(base + 1) % 8], 1);
        chk("R5 window2 power", r_pow[(base + 1) % 8], 2);

        // R7 windows closing while busy are dropped
        base = nres;
        setup(1, 0, 0, 4, 1);
        do_clr();
        run(40, 40, 0);
        chk("R7 busy during division", busy, 1);
        repeat (200) @(negedge clk);
        chk("R7 result count", nres, base + 1);
        chk("R7 first window dyn", r_dyn[base % 8], 4);

        // R8 saturation of both counters
        base = nres;
        setup(1, 1, 0, 5000, 1);
        do_clr();
        run(5000, 5000, 5000);
        wait_res(base + 1, "R8");
        chk("R8 saturated dyn", r_dyn[base % 8], 8190);
        chk("R8 saturated power", r_pow[base % 8], 1);

        // R6 outputs hold after the pulse
        repeat (10) @(negedge clk);
        chk("R6 valid low", res_valid, 0);
        chk("R6 dyn held", dyn_energy, 8190);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule